// File: doc/BRIEF.md
# Level and edge interrupt input tracker

This block sits between a bank of external interrupt request lines and a priority selector. For every interrupt it holds four pieces of state: the last recorded line level, an enable bit, a trigger-mode bit (level-sensitive or edge-triggered) and a pending bit. A register interface drives per-interrupt strobes that set or clear the enable and the pending bit. It also writes trigger-mode fields one configuration byte at a time. A completion notification carries the ID of an interrupt whose handler has finished. The block presents its pending and enable vectors to the downstream selector.

The request lines are asynchronous. They pass through a two-flop synchronizer before level and edge detection. An edge-triggered line latches pending once on its rising edge. A level-sensitive line that is still high becomes pending again whenever software enables it or completes its handler, so the request is not lost while the source keeps asserting. The lowest interrupt IDs are reserved: they are always enabled and always edge-triggered.

Top module: `irq_line_tracker`

## Requirements
- R1: After reset every pending bit is 0. The enable bits of IDs below FIXED_IRQS (16) read 1 and all others read 0. Every non-reserved interrupt starts level-sensitive.
- R2: A rising edge on a synchronized line sets pending when the interrupt is edge-triggered or enabled. A rise on a disabled level-sensitive line leaves pending at 0. Pending shows the rise three clock edges after the raw input changes: two synchronizer stages, then the state register.
- R3: A falling line, or a line whose level does not change, never changes the pending bit.
- R4: A set-enable strobe on a level-sensitive interrupt whose synchronized line is high also sets its pending bit on the same clock edge that sets the enable.
- R5: A completion with done_id_i equal to an enabled, level-sensitive interrupt whose line is still high sets its pending bit again. If the line is low, pending is not set.
- R6: A trigger-mode write with cfg_sel_i = k covers IDs 4k..4k+3. Bit 2j+1 of cfg_byte_i selects edge mode (1) or level mode (0) for ID 4k+j. Bit 2j has no effect.
- R7: IDs below FIXED_IRQS ignore clear-enable and trigger-mode writes. They stay enabled and edge-triggered, so a completion never re-pends them.
- R8: A clear-pending strobe clears pending whatever the line level. It takes precedence over set-pending and every other set condition in the same cycle.
- R9: A set-pending strobe sets pending whatever the enable and trigger mode.
- R10: Set-enable sets the enable bit and clear-enable clears it. When both strike the same non-reserved interrupt in one cycle, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_raw_i | input | NUM_IRQ | Asynchronous interrupt request lines |
| set_en_i | input | NUM_IRQ | Set-enable strobes, one per interrupt |
| clr_en_i | input | NUM_IRQ | Clear-enable strobes |
| set_pend_i | input | NUM_IRQ | Set-pending strobes |
| clr_pend_i | input | NUM_IRQ | Clear-pending strobes |
| done_vld_i | input | 1 | Completion notification valid |
| done_id_i | input | $clog2(NUM_IRQ) | ID of the completed interrupt |
| cfg_we_i | input | 1 | Trigger-mode byte write strobe |
| cfg_sel_i | input | $clog2(NUM_IRQ/4) | Trigger-mode byte index (four IDs per byte) |
| cfg_byte_i | input | 8 | Trigger-mode byte data, two bits per ID |
| pend_o | output | NUM_IRQ | Pending vector to the priority selector |
| en_o | output | NUM_IRQ | Enable vector to the priority selector |

## Verification
The bench aims at level re-pending. It enables a line that is already high, completes a handler while the line is held or dropped, and clears pending under a steady high line. A design that latched level lines only on edges would lose those requests, and one that re-evaluated a steady level every cycle would undo a clear-pending. The bench also hits the even "don't care" bit of a configuration pair, clear-versus-set collisions for both enable and pending, and reserved IDs under disable and reconfiguration attempts. Each of these shows up as a wrong pending or enable bit. Long random runs then compare both vectors every cycle against a bench-side model built from the requirements.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;

  // Trigger-mode byte layout: four IDs per byte, two bits each, upper bit = edge.
  localparam int unsigned IDS_PER_CFG_BYTE = 4;
  localparam int unsigned CFG_EDGE_BIT     = 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
  import irq_trk_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned SELW   = $clog2(NUM_IRQ / IDS_PER_CFG_BYTE)
) (
  input  logic               cfg_we_i,
  input  logic [SELW-1:0]    cfg_sel_i,
  input  logic [7:0]         cfg_byte_i,
  output logic [NUM_IRQ-1:0] mode_we_o,
  output logic [NUM_IRQ-1:0] mode_edge_o
);
  logic [IDS_PER_CFG_BYTE-1:0] unused_mode_lo;

  for (genvar j = 0; j < IDS_PER_CFG_BYTE; j++) begin : g_lo
    assign unused_mode_lo[j] = cfg_byte_i[2*j + (1 - CFG_EDGE_BIT)];
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign mode_we_o[i]   = cfg_we_i && (cfg_sel_i == SELW'(i / IDS_PER_CFG_BYTE));
    assign mode_edge_o[i] = cfg_byte_i[2*(i % IDS_PER_CFG_BYTE) + CFG_EDGE_BIT];
  end
endmodule

// File: rtl/irq_cell.sv
module irq_cell
  import irq_trk_pkg::*;
#(
  parameter bit FIXED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic set_en_i,
  input  logic clr_en_i,
  input  logic set_pend_i,
  input  logic clr_pend_i,
  input  logic done_i,
  input  logic mode_we_i,
  input  logic mode_edge_i,
  output logic pend_o,
  output logic en_o
);
  logic       lvl_q, lvl_ld;
  logic       en_q;
  trig_mode_e mode_q;
  logic       is_edge;
  logic       rise, set_req;
  logic       pend_q, pend_d, pend_ld;

  // recorded line level
  always_comb lvl_ld = line_i ^ lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= 1'b0;
    else if (lvl_ld) lvl_q <= line_i;
  end

  if (FIXED) begin : g_fixed
    logic unused_fixed_in;
    assign unused_fixed_in = ^{set_en_i, clr_en_i, mode_we_i, mode_edge_i};
    assign en_q   = 1'b1;
    assign mode_q = TRIG_EDGE;
  end else begin : g_prog
    logic       en_d, en_ld;
    trig_mode_e mode_d;

    always_comb begin
      en_ld  = set_en_i | clr_en_i;
      en_d   = ~clr_en_i;
      mode_d = mode_edge_i ? TRIG_EDGE : TRIG_LEVEL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= 1'b0;
      else if (en_ld) en_q <= en_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_q <= TRIG_LEVEL;
      else if (mode_we_i) mode_q <= mode_d;
    end

    // R10
    clr_en_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en_i |=> !en_o);
  end

  // pending next-state
  always_comb begin
    is_edge = (mode_q == TRIG_EDGE);
    rise    = line_i & ~lvl_q;
    set_req = set_pend_i
            | (rise & (is_edge | en_q))
            | (~is_edge & line_i & (set_en_i | (done_i & en_q)));
    pend_ld = clr_pend_i | set_req;
    pend_d  = ~clr_pend_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_ld) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

  // R8
  clr_pend_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend_i |=> !pend_o);
  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_pend_i) |=> pend_o);
  // R2
  edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_i && !lvl_q && is_edge && !clr_pend_i) |=> pend_o);
  // R4
  level_enable_repend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en_i && !is_edge && line_i && !clr_pend_i) |=> pend_o);
  // R5
  level_done_repend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && en_o && !is_edge && line_i && !clr_pend_i) |=> pend_o);
  // R9
  set_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pend_i && !clr_pend_i) |=> pend_o);
endmodule

// File: rtl/irq_line_tracker.sv
module irq_line_tracker
  import irq_trk_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = 32,
  parameter int unsigned FIXED_IRQS  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDW        = $clog2(NUM_IRQ),
  localparam int unsigned SELW       = $clog2(NUM_IRQ / IDS_PER_CFG_BYTE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_raw_i,
  input  logic [NUM_IRQ-1:0] set_en_i,
  input  logic [NUM_IRQ-1:0] clr_en_i,
  input  logic [NUM_IRQ-1:0] set_pend_i,
  input  logic [NUM_IRQ-1:0] clr_pend_i,
  input  logic               done_vld_i,
  input  logic [IDW-1:0]     done_id_i,
  input  logic               cfg_we_i,
  input  logic [SELW-1:0]    cfg_sel_i,
  input  logic [7:0]         cfg_byte_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] en_o
);
  logic [1:0]         rst_pipe_q;
  logic               rst_n_int;
  logic [NUM_IRQ-1:0] line_sync;
  logic [NUM_IRQ-1:0] mode_we, mode_edge;
  logic [NUM_IRQ-1:0] done_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  irq_sync #(.W(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (irq_raw_i),
    .q_o   (line_sync)
  );

  irq_cfg_decode #(.NUM_IRQ(NUM_IRQ)) u_cfg (
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_byte_i  (cfg_byte_i),
    .mode_we_o   (mode_we),
    .mode_edge_o (mode_edge)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cell
    assign done_hit[i] = done_vld_i && (done_id_i == IDW'(i));

    irq_cell #(.FIXED(i < FIXED_IRQS)) u_cell (
      .clk         (clk),
      .rst_n       (rst_n_int),
      .line_i      (line_sync[i]),
      .set_en_i    (set_en_i[i]),
      .clr_en_i    (clr_en_i[i]),
      .set_pend_i  (set_pend_i[i]),
      .clr_pend_i  (clr_pend_i[i]),
      .done_i      (done_hit[i]),
      .mode_we_i   (mode_we[i]),
      .mode_edge_i (mode_edge[i]),
      .pend_o      (pend_o[i]),
      .en_o        (en_o[i])
    );
  end

  // R7
  fixed_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (|clr_en_i[FIXED_IRQS-1:0]) |=> (&en_o[FIXED_IRQS-1:0]));
endmodule

// File: tb/irq_line_tracker_bench.sv
module irq_line_tracker_bench;
  localparam int N     = 32;
  localparam int FIXED = 16;
  localparam int IDW   = $clog2(N);
  localparam int SELW  = $clog2(N / 4);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    raw, s_en, c_en, s_pd, c_pd;
  logic            dv;
  logic [IDW-1:0]  did;
  logic            cwe;
  logic [SELW-1:0] csel;
  logic [7:0]      cbyte;
  logic [N-1:0]    pend_o, en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_line_tracker u_irq_line_tracker (
    .clk(clk), .rst_n(rst_n), .irq_raw_i(raw), .set_en_i(s_en), .clr_en_i(c_en),
    .set_pend_i(s_pd), .clr_pend_i(c_pd), .done_vld_i(dv), .done_id_i(did),
    .cfg_we_i(cwe), .cfg_sel_i(csel), .cfg_byte_i(cbyte),
    .pend_o(pend_o), .en_o(en_o));

  // requirement-level model
  logic [N-1:0] m_s1, m_s2, m_lvl, m_en, m_edge, m_pend;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_lvl <= '0; m_pend <= '0;
      m_en <= {{(N-FIXED){1'b0}}, {FIXED{1'b1}}};
      m_edge <= {{(N-FIXED){1'b0}}, {FIXED{1'b1}}};
    end else begin
      for (int i = 0; i < N; i++) begin
        bit line, setp, dh;
        line = m_s2[i];
        dh   = dv && (did == IDW'(i));
        setp = s_pd[i] || (line && !m_lvl[i] && (m_edge[i] || m_en[i]))
               || (!m_edge[i] && line && (s_en[i] || (dh && m_en[i])));
        if (c_pd[i]) m_pend[i] <= 1'b0;
        else if (setp) m_pend[i] <= 1'b1;
        if (i >= FIXED) begin
          if (c_en[i]) m_en[i] <= 1'b0;
          else if (s_en[i]) m_en[i] <= 1'b1;
          if (cwe && csel == SELW'(i / 4)) m_edge[i] <= cbyte[2*(i%4)+1];
        end
        m_lvl[i] <= line;
      end
      m_s2 <= m_s1;
      m_s1 <= raw;
    end
  end

  task automatic chk_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr_strobes();
    s_en = '0; c_en = '0; s_pd = '0; c_pd = '0;
    dv = 1'b0; did = '0; cwe = 1'b0; csel = '0; cbyte = '0;
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      clr_strobes();
    end
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd2024);
    rst_n = 1'b0; raw = '0; clr_strobes();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk_vec("R1 pending after reset", pend_o, '0);
    chk_vec("R1 enable after reset", en_o, 32'h0000_FFFF);

    // R2: disabled level-sensitive rise does not pend
    raw[20] = 1'b1; tick(3);
    chk_bit("R2 disabled level rise", pend_o[20], 1'b0);
    // R4: enabling a high level line pends it
    s_en[20] = 1'b1; tick();
    chk_bit("R4 enable high level", pend_o[20], 1'b1);
    chk_bit("R10 set enable", en_o[20], 1'b1);
    // R8: clear under a high line, steady line does nothing
    c_pd[20] = 1'b1; tick();
    chk_bit("R8 clear under high line", pend_o[20], 1'b0);
    tick(3);
    chk_bit("R3 steady level no action", pend_o[20], 1'b0);
    // R5: completion re-pends while high
    dv = 1'b1; did = 5'd20; tick();
    chk_bit("R5 completion line high", pend_o[20], 1'b1);
    c_pd[20] = 1'b1; tick();
    raw[20] = 1'b0; tick(3);
    dv = 1'b1; did = 5'd20; tick();
    chk_bit("R5 completion line low", pend_o[20], 1'b0);
    // R2: enabled level rise pends
    s_en[21] = 1'b1; tick();
    raw[21] = 1'b1; tick(3);
    chk_bit("R2 enabled level rise", pend_o[21], 1'b1);
    // R6: byte 6 covers 24..27; 0x06 -> 24 edge, 25 bit0-of-pair only -> level
    cwe = 1'b1; csel = 3'd6; cbyte = 8'h06; tick();
    raw[24] = 1'b1; raw[25] = 1'b1; tick(3);
    chk_bit("R6 edge mode by upper bit", pend_o[24], 1'b1);
    chk_bit("R6 lower bit no effect", pend_o[25], 1'b0);
    raw[24] = 1'b0; tick(4);
    chk_bit("R3 fall keeps pending", pend_o[24], 1'b1);
    // R9 / R8 collisions
    s_pd[30] = 1'b1; tick();
    chk_bit("R9 set pending while disabled", pend_o[30], 1'b1);
    s_pd[31] = 1'b1; c_pd[31] = 1'b1; c_pd[30] = 1'b1; tick();
    chk_bit("R8 clear wins over set", pend_o[31], 1'b0);
    chk_bit("R8 clear pending", pend_o[30], 1'b0);
    // R7: reserved IDs
    c_en[3] = 1'b1; tick();
    chk_bit("R7 clear enable ignored", en_o[3], 1'b1);
    cwe = 1'b1; csel = 3'd0; cbyte = 8'h00; tick();
    raw[1] = 1'b1; tick(3);
    chk_bit("R7 still edge triggered", pend_o[1], 1'b1);
    c_pd[1] = 1'b1; tick();
    dv = 1'b1; did = 5'd1; tick();
    chk_bit("R7 no level re-pend on completion", pend_o[1], 1'b0);
    raw[1] = 1'b0;
    // R10
    s_en[22] = 1'b1; c_en[22] = 1'b1; tick();
    chk_bit("R10 clear enable wins", en_o[22], 1'b0);
    s_en[22] = 1'b1; tick();
    chk_bit("R10 set enable", en_o[22], 1'b1);
    c_en[22] = 1'b1; tick();
    chk_bit("R10 clear enable", en_o[22], 1'b0);
    chk_vec("R1 directed pending vs model", pend_o, m_pend);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      chk_vec("R2 R3 R4 R5 R8 R9 random pending", pend_o, m_pend);
      chk_vec("R6 R7 R10 random enable", en_o, m_en);
      clr_strobes();
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(15) == 0) raw[i] = ~raw[i];
        s_en[i] = ($urandom_range(31) == 0);
        c_en[i] = ($urandom_range(31) == 0);
        s_pd[i] = ($urandom_range(63) == 0);
        c_pd[i] = ($urandom_range(23) == 0);
      end
      dv    = ($urandom_range(3) == 0);
      did   = IDW'($urandom_range(N - 1));
      cwe   = ($urandom_range(7) == 0);
      csel  = SELW'($urandom_range(N / 4 - 1));
      cbyte = 8'($urandom);
    end
    @(negedge clk);
    chk_vec("R2 final pending", pend_o, m_pend);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule